// File: doc/BRIEF.md
# Write-Only I2C Register Slave

This block is a slave-only receiver for a two-wire serial bus. It watches SCL and an open-drain SDA line with a fast system clock and recognises START and STOP conditions. It compares the first byte after START with a fixed seven-bit device address plus a write direction bit, and it acknowledges every byte it accepts. Each data byte that follows is handed to a register file as a one-cycle write strobe that carries the byte. A transaction can carry one data byte or many. Reads are never answered. After a STOP the block stays silent until a new START brings a matching address.

The bus cannot be stalled, because the block does not stretch the clock. For that reason the write output is a valid-only stream with no ready input, and the consumer must take each `wr_valid` pulse in the cycle it appears. SDA is never driven high: `sda_oe` is an active-high pull-down enable for an external open-drain pad. SCL and SDA are re-timed through a synchronizer. The system clock must run at no less than 16 times the SCL rate, which is at most 400 kHz. The active-low reset clears the block and keeps it off the bus for as long as it is held.

Top module: `i2c_wr_slave`

## Requirements
- R1: While `rst_n` is low, `sda_oe` and `wr_valid` are 0 and all bus traffic is ignored. After release, the block is idle with `sda_oe` = 0 and `wr_valid` = 0, and it responds only after a new START.
- R2: A START is SDA falling while SCL is high, and it begins address reception. A STOP is SDA rising while SCL is high. After a STOP, bytes clocked without a new START get no acknowledge and produce no write.
- R3: An address byte of 8'hDE, sent MSB first and sampled on SCL rising edges (seven-bit address 7'h6F, bit 0 = 0 for write), is acknowledged. `sda_oe` is 1 through the high phase of the ninth SCL pulse.
- R4: An address byte whose upper seven bits differ from 7'h6F gets no acknowledge. Every later byte up to the next START or STOP is ignored.
- R5: A matching address with bit 0 = 1 (read) gets no acknowledge. The following bytes are ignored and produce no write.
- R6: Each data byte, received MSB first, raises `wr_valid` for exactly one clock with `wr_data` equal to the byte. The pulse is visible in the third clock cycle after the eighth bit's SCL rising edge reaches `scl_i`.
- R7: Any number of data bytes may follow an accepted address before STOP. Every one of them is acknowledged and written separately, in bus order.
- R8: `sda_oe` is 0 during the SCL high phase of every address and data bit. It is released after the ninth SCL pulse falls, before the next bit is sampled.
- R9: A repeated START in the middle of a byte discards the partial byte without a write. Address matching then restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset; the bus is ignored while low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired value) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| wr_valid | output | 1 | One-cycle write strobe, no back-pressure |
| wr_data | output | 8 | Received data byte, valid with wr_valid |

## Verification
Every result reaches the ports three clock edges after the bus edge that causes it. Two of those edges are the synchronizer stages and one is the edge register. The write strobe therefore belongs in a single cycle: the bench records the cycle in which it raises SCL for the eighth bit of each data byte, adds three, and on every clock compares `wr_valid` and `wr_data` against that queue of due cycles. Any pulse in another cycle, or a missing pulse, is an error. The acknowledge pull-down moves three cycles after an SCL fall, so the bench samples `sda_oe` four cycles into each SCL high phase, when it has settled.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,   // waiting for START
    PH_ADDR,   // shifting in address byte
    PH_ACK,    // driving / releasing acknowledge
    PH_DATA,   // shifting in data byte
    PH_SKIP    // not addressed, wait for START or STOP
  } rx_phase_e;

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain  <= '1;
        last_q <= 1'b1;
      end else begin
        chain  <= {chain[STAGES-2:0], async_i[g]};
        last_q <= chain[STAGES-1];
      end
    end

    assign sync_o[g] = chain[STAGES-1];
    assign prev_o[g] = last_q;
  end

endmodule

// File: rtl/i2cw_edges.sv
module i2cw_edges (
  input  logic scl_s,
  input  logic scl_d,
  input  logic sda_s,
  input  logic sda_d,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_held_high;

  always_comb begin
    scl_held_high = scl_s & scl_d;
    scl_rise      = scl_s & ~scl_d;
    scl_fall      = ~scl_s & scl_d;
    start_det     = scl_held_high & sda_d & ~sda_s;
    stop_det      = scl_held_high & ~sda_d & sda_s;
  end

endmodule

// File: rtl/i2cw_rx.sv
module i2cw_rx
  import i2cw_pkg::*;
#(
  parameter int              ADDR_W   = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h6F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  output logic            sda_oe,
  output logic            wr_valid,
  output logic [ADDR_W:0] wr_data
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] WR_ADDR_BYTE = {DEV_ADDR, 1'b0};

  rx_phase_e         phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-2:0] shreg;
  logic [BYTE_W-1:0] byte_nx;
  logic              byte_done;

  always_comb begin
    byte_nx   = {shreg, sda_s};
    byte_done = scl_rise && (bit_cnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_det) begin
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        phase   <= PH_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else begin
        unique case (phase)
          PH_ADDR, PH_DATA: begin
            if (scl_rise) begin
              shreg   <= byte_nx[BYTE_W-2:0];
              bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
            end
            if (byte_done) begin
              if (phase == PH_DATA) begin
                wr_valid <= 1'b1;
                wr_data  <= byte_nx;
                phase    <= PH_ACK;
              end else begin
                phase <= (byte_nx == WR_ADDR_BYTE) ? PH_ACK : PH_SKIP;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              if (!sda_oe) begin
                sda_oe <= 1'b1;
              end else begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                phase   <= PH_DATA;
              end
            end
          end
          PH_IDLE, PH_SKIP: begin
            sda_oe <= 1'b0;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave #(
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h6F,
  parameter int                SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic            wr_valid,
  output logic [ADDR_W:0] wr_data
);

  localparam int LINES = 2;
  localparam int SCL_IX = 1;
  localparam int SDA_IX = 0;

  logic [LINES-1:0] bus_s;
  logic [LINES-1:0] bus_d;
  logic scl_s, scl_d, sda_s, sda_d;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2cw_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (LINES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({scl_i, sda_i}),
    .sync_o  (bus_s),
    .prev_o  (bus_d)
  );

  assign scl_s = bus_s[SCL_IX];
  assign scl_d = bus_d[SCL_IX];
  assign sda_s = bus_s[SDA_IX];
  assign sda_d = bus_d[SDA_IX];

  i2cw_edges u_edges (
    .scl_s     (scl_s),
    .scl_d     (scl_d),
    .sda_s     (sda_s),
    .sda_d     (sda_d),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cw_rx #(
    .ADDR_W   (ADDR_W),
    .DEV_ADDR (DEV_ADDR)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data)
  );

endmodule

// File: rtl/i2cw_checks.sv
module i2cw_checks (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic sda_oe,
  input logic wr_valid
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!sda_oe && !wr_valid)
        else $error("bus outputs active during reset");
    end
  end

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_write_not_in_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !sda_oe);

  assert_oe_rise_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  assert_oe_fall_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);

  assert_start_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe && !wr_valid);

endmodule

bind i2c_wr_slave i2cw_checks u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_s     (scl_s),
  .start_det (start_det),
  .sda_oe    (sda_oe),
  .wr_valid  (wr_valid)
);

// File: tb/test_i2c_wr_slave.sv
module test_i2c_wr_slave;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic       wr_valid;
  logic [7:0] wr_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int due_q[$];
  logic [7:0] dat_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign sda_line = sda_m & ~sda_oe;

  i2c_wr_slave i_i2c_wr_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_data  (wr_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model for the write stream (R6, R7): compared every clock
  always @(negedge clk) begin
    if (due_q.size() > 0 && cyc == due_q[0]) begin
      chk("R6 strobe", int'(wr_valid), 1);
      chk("R6 data", int'(wr_data), int'(dat_q[0]));
      void'(due_q.pop_front());
      void'(dat_q.pop_front());
    end else if (wr_valid) begin
      chk("R6 unexpected strobe", 1, 0);
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b0; tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b1; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] b, input int exp_ack,
                           input bit exp_wr, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(4);
      scl_m = 1'b1;
      if (exp_wr && i == 0) begin
        due_q.push_back(cyc + 3);
        dat_q.push_back(b);
      end
      tick(4);
      chk("R8 no drive on bit", int'(sda_oe), 0);
      tick(4);
      scl_m = 1'b0; tick(4);
    end
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    chk(req, int'(sda_oe), exp_ack);
    tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic partial_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(4);
      scl_m = 1'b1; tick(8);
      scl_m = 1'b0; tick(4);
    end
  endtask

  initial begin
    tick(3);
    chk("R1 reset oe", int'(sda_oe), 0);
    chk("R1 reset strobe", int'(wr_valid), 0);
    // R1: traffic under reset is ignored
    bus_start();
    send_byte(8'hDE, 0, 1'b0, "R1 no ack in reset");
    send_byte(8'h55, 0, 1'b0, "R1 no data ack in reset");
    bus_stop();
    rst_n = 1'b1; tick(6);
    chk("R1 idle after release", int'(sda_oe), 0);

    // R3, R6: single-byte write
    bus_start();
    send_byte(8'hDE, 1, 1'b0, "R3 address ack");
    send_byte(8'hA5, 1, 1'b1, "R7 data ack");
    bus_stop();
    tick(4);
    chk("R8 released after stop", int'(sda_oe), 0);

    // R7: multi-byte write, boundary values
    bus_start();
    send_byte(8'hDE, 1, 1'b0, "R3 address ack");
    send_byte(8'h00, 1, 1'b1, "R7 byte0 ack");
    send_byte(8'hFF, 1, 1'b1, "R7 byte1 ack");
    send_byte(8'h80, 1, 1'b1, "R7 byte2 ack");
    send_byte(8'h01, 1, 1'b1, "R7 byte3 ack");
    bus_stop();

    // R2: bytes after STOP without START are ignored
    send_byte(8'hDE, 0, 1'b0, "R2 no ack after stop");
    send_byte(8'h3C, 0, 1'b0, "R2 data ignored after stop");
    bus_stop();

    // R4: wrong address (single bit off)
    bus_start();
    send_byte(8'hDC, 0, 1'b0, "R4 wrong address no ack");
    send_byte(8'h11, 0, 1'b0, "R4 data ignored");
    bus_stop();
    bus_start();
    send_byte(8'h5E, 0, 1'b0, "R4 msb differs no ack");
    bus_stop();

    // R5: read request to own address
    bus_start();
    send_byte(8'hDF, 0, 1'b0, "R5 read no ack");
    send_byte(8'h22, 0, 1'b0, "R5 data ignored");
    bus_stop();

    // R9: repeated START mid data byte
    bus_start();
    send_byte(8'hDE, 1, 1'b0, "R3 address ack");
    partial_bits(8'hF0, 3);
    bus_start();
    send_byte(8'hDE, 1, 1'b0, "R9 address after restart");
    send_byte(8'h69, 1, 1'b1, "R9 data after restart");
    // R9: repeated START to a foreign address aborts acceptance
    bus_start();
    send_byte(8'hA0, 0, 1'b0, "R9 restart foreign address");
    send_byte(8'h77, 0, 1'b0, "R9 no write after foreign");
    bus_stop();

    // R1: reset pulse in mid transaction drops the session
    bus_start();
    send_byte(8'hDE, 1, 1'b0, "R3 address ack");
    rst_n = 1'b0; tick(4);
    chk("R1 oe under reset", int'(sda_oe), 0);
    rst_n = 1'b1; tick(4);
    send_byte(8'h99, 0, 1'b0, "R1 no ack after reset");
    bus_stop();

    tick(10);
    chk("R6 all strobes seen", due_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule